// File: doc/BRIEF.md
# Vector Odd-Lane Widening Multiplier

This unit executes one packed-SIMD operation on 128-bit vectors: an unsigned multiply of the odd-numbered 16-bit lanes. It decodes a 32-bit instruction word and raises a combinational match flag when the word holds this operation. On a clock edge where the input strobe is high and the word matches, the unit takes two 128-bit sources and multiplies them lane by lane. Lanes are counted from the most significant end.

A 128-bit vector holds eight half-word lanes, and only lanes 1, 3, 5 and 7 take part. Each product keeps its full 32 bits and fills one of four word lanes in the result. The result, a valid pulse and the destination register index from the instruction appear one clock after the unit accepts an input. The result and index then stay unchanged until the next accepted input. The unit touches no status, condition or saturation state.

Top module: `vec_odd_mul`

## Requirements
- R1: `match_o` is high exactly when instruction bits [31:26] equal 4 and bits [10:0] equal 72 (word 0x10000048 with the register fields at zero). The register fields in bits [25:11] do not affect it.
- R2: The even half-word lanes 0, 2, 4 and 6 have no effect on the result. Here lane k is bits [127-16k -: 16]. If the odd lanes of an operand are zero, the result is zero whatever the even lanes hold.
- R3: Result word lane i, at bits [127-32i -: 32] for i = 0..3, equals the unsigned product of half-word lane 2i+1 of A and half-word lane 2i+1 of B.
- R4: Products are neither truncated nor saturated. All-ones operands give 0xFFFE0001 in every word lane.
- R5: `res_valid_o` rises the clock after an edge where `in_valid_i` and `match_o` are both high. In that cycle `res_dst_o` shows instruction bits [25:21] of the accepted word.
- R6: `res_valid_o` stays low the clock after an edge where `in_valid_i` is low or the word does not match.
- R7: `res_o` and `res_dst_o` keep their last accepted value until the next accepted input.
- R8: While the active-high synchronous reset `rst` is asserted, `res_valid_o`, `res_o` and `res_dst_o` are cleared to zero on each clock edge.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word |
| in_valid_i | input | 1 | Source operands valid |
| src_a_i | input | 128 | Source vector A |
| src_b_i | input | 128 | Source vector B |
| match_o | output | 1 | Instruction word is the odd unsigned half-word multiply |
| res_valid_o | output | 1 | Result valid, one clock after acceptance |
| res_dst_o | output | 5 | Destination register index of the held result |
| res_o | output | 128 | Four 32-bit products |

## Verification
The only state is the result register, its valid bit and its index. Any fault in that state shows at the ports on the very next clock. A wrong lane select or a truncated product corrupts `res_o` in the cycle after acceptance. Loss of the hold shows as `res_o` changing on an idle cycle. The reference model is compared with all outputs on every clock, so each of these faults is caught in the cycle where it first appears. The same holds for a decode that wrongly uses the register fields.

// File: rtl/vec_odd_mul.sv
module vec_odd_mul #(
  parameter int HW    = 16,
  parameter int NLANE = 4,
  parameter int RIDX  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [31:0]             instr_i,
  input  logic                    in_valid_i,
  input  logic [2*HW*NLANE-1:0]   src_a_i,
  input  logic [2*HW*NLANE-1:0]   src_b_i,
  output logic                    match_o,
  output logic                    res_valid_o,
  output logic [RIDX-1:0]         res_dst_o,
  output logic [2*HW*NLANE-1:0]   res_o
);
  localparam int PW = 2 * HW;
  localparam int VW = PW * NLANE;
  localparam logic [5:0]  MAJOR = 6'd4;
  localparam logic [10:0] MINOR = 11'd72;

  logic [VW-1:0] prod;
  logic          take;

  assign match_o = (instr_i[31:26] == MAJOR) && (instr_i[10:0] == MINOR);
  assign take    = in_valid_i && match_o;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [HW-1:0] a_h, b_h;
    assign a_h = src_a_i[VW-1-(2*i+1)*HW -: HW];
    assign b_h = src_b_i[VW-1-(2*i+1)*HW -: HW];
    assign prod[VW-1-i*PW -: PW] = PW'(a_h) * PW'(b_h);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
      res_dst_o   <= '0;
    end else begin
      res_valid_o <= take;
      if (take) begin
        res_o     <= prod;
        res_dst_o <= instr_i[25:21];
      end
    end
  end
endmodule

module vec_odd_mul_chk #(
  parameter int HW    = 16,
  parameter int NLANE = 4,
  parameter int RIDX  = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic [31:0]           instr_i,
  input logic                  in_valid_i,
  input logic [2*HW*NLANE-1:0] src_a_i,
  input logic [2*HW*NLANE-1:0] src_b_i,
  input logic                  match_o,
  input logic                  res_valid_o,
  input logic [RIDX-1:0]       res_dst_o,
  input logic [2*HW*NLANE-1:0] res_o
);
  localparam int VW = 2 * HW * NLANE;

  function automatic logic [VW-1:0] odd_ref(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < NLANE; i++) begin
      r = (r << (2*HW)) | VW'(longint'(a[VW-1-(2*i+1)*HW -: HW]) * longint'(b[VW-1-(2*i+1)*HW -: HW]));
    end
    return r;
  endfunction

  // R5
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && match_o) |=> (res_valid_o && res_dst_o == $past(instr_i[25:21])));
  // R6
  a_r6_no_accept: assert property (@(posedge clk) disable iff (rst)
    !(in_valid_i && match_o) |=> !res_valid_o);
  // R3
  a_r3_lane_product: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && match_o) |=> (res_o == odd_ref($past(src_a_i), $past(src_b_i))));
  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid_i && match_o) |=> ($stable(res_o) && $stable(res_dst_o)));
  // R8
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!res_valid_o && res_o == '0));
endmodule

bind vec_odd_mul vec_odd_mul_chk #(.HW(HW), .NLANE(NLANE), .RIDX(RIDX)) u_chk (
  .clk(clk), .rst(rst), .instr_i(instr_i), .in_valid_i(in_valid_i),
  .src_a_i(src_a_i), .src_b_i(src_b_i), .match_o(match_o),
  .res_valid_o(res_valid_o), .res_dst_o(res_dst_o), .res_o(res_o));

// File: tb/test_vec_odd_mul.sv
`timescale 1ns/1ps
module test_vec_odd_mul;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  instr = '0;
  logic         in_v = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic         match, rv;
  logic [4:0]   dst;
  logic [127:0] res;

  int tests = 0, fails = 0, cyc = 0;
  bit started = 0;
  string phase = "R8";

  logic         exp_v = 1'b0;
  logic [127:0] exp_r = '0;
  logic [4:0]   exp_d = '0;

  always #2.5 clk = ~clk;

  vec_odd_mul i_vec_odd_mul (
    .clk(clk), .rst(rst), .instr_i(instr), .in_valid_i(in_v),
    .src_a_i(a), .src_b_i(b), .match_o(match), .res_valid_o(rv),
    .res_dst_o(dst), .res_o(res));

  function automatic bit is_op(input logic [31:0] w);
    return (w[31:26] == 6'd4) && (w[10:0] == 11'd72);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      longint unsigned p;
      p = ((x >> (112 - 16*(2*i+1))) & 128'hFFFF) * ((y >> (112 - 16*(2*i+1))) & 128'hFFFF);
      r[127-32*i -: 32] = p[31:0];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    started = 1;
    if (rst) begin
      exp_v = 0; exp_r = '0; exp_d = '0;
    end else if (in_v && is_op(instr)) begin
      exp_v = 1; exp_r = model(a, b); exp_d = instr[25:21];
    end else exp_v = 0;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) if (started) begin
    tests++;
    if (match !== is_op(instr)) begin
      fails++; $display("FAIL R1 match: got %b exp %b (instr %h)", match, is_op(instr), instr);
    end
    tests++;
    if (rv !== exp_v) begin
      fails++; $display("FAIL R5/R6 [%s] valid: got %b exp %b", phase, rv, exp_v);
    end
    tests++;
    if (res !== exp_r || dst !== exp_d) begin
      fails++; $display("FAIL R3/R7 [%s] result: got %h/%0d exp %h/%0d", phase, res, dst, exp_r, exp_d);
    end
  end

  task automatic issue(input logic [31:0] w, input logic v, input logic [127:0] x, input logic [127:0] y, input string ph);
    @(posedge clk); #1;
    instr = w; in_v = v; a = x; b = y; phase = ph;
  endtask

  function automatic logic [31:0] op(input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2);
    return {6'd4, d, s1, s2, 11'd72};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    issue(op(5'd3, 5'd1, 5'd2), 1, '1, '1, "R4");
    issue(op(5'd7, 5'd0, 5'd0), 1, 128'h1234_0000_ABCD_0000_FFFF_0000_5555_0000,
          128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, "R2");
    issue(op(5'd9, 5'd4, 5'd4), 1, 128'h0000_0002_0000_0003_0000_0004_0000_8000,
          128'hAAAA_0005_BBBB_0007_CCCC_0009_DDDD_0002, "R3");
    issue(32'h1000_0049, 1, '1, '1, "R6");
    issue(32'h1400_0048, 1, 128'h5, 128'h7, "R6");
    issue(op(5'd31, 5'd1, 5'd1), 0, '1, '1, "R6");
    issue(32'h0, 0, '0, '0, "R7");
    issue(32'h0, 0, '0, '0, "R7");
    issue(op(5'd1, 5'd1, 5'd1), 1, 128'h0001_0001_0001_0001_0001_0001_0001_0001, '1, "R2");
    issue(op(5'd2, 5'd2, 5'd2), 1, '1, '1, "R5");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = ($urandom % 3 != 0) ? {6'd4, 15'($urandom), 11'd72} : $urandom;
      issue(w, 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, "R3");
    end
    issue(op(5'd4, 5'd4, 5'd4), 1, '1, '1, "R8");
    #1 rst = 1;
    issue(32'h0, 0, '0, '0, "R8");
    issue(32'h0, 0, '0, '0, "R8");
    #1 rst = 0;
    issue(32'h0, 0, '0, '0, "R7");
    @(posedge clk); @(negedge clk); #1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule